// File: doc/BRIEF.md
# Four-Mode Serial Port with Address Filtering

This block is a serial port with one clocked shift mode and three framed asynchronous modes. In the framed modes it transmits and receives at the same time. One line carries transmit data and a second line carries receive data. In the shift mode the block drives a shift clock of its own. Data moves over the receive line in either direction, and an output enable reports when the block drives it.

A small register port gives access to a data register, a control register, a baud reload value and a status register. Both directions hold two frames: one in the shifter and one in a buffer. Two modes use a nine-bit frame. In one of them the ninth bit acts as an address marker, and frames without it are dropped. Even parity can take the place of the last data bit. All bit timing comes from a 15-bit reload counter that runs at eight ticks per bit.

Top module: `sio_port`

## Requirements
- R1: After reset, txd and sclk are 1, rxd_oe, tx_irq and rx_irq are 0, and the status register (address 3) reads 0.
- R2: Control register at address 1 has mode in bits 1:0, parity enable in bit 2, receive enable in bit 3 and transmit ninth bit in bit 4. With mode 1, writing address 0 sends a frame on txd: a 0 start bit, then 8 data bits LSB first, then a 1 stop bit.
- R3: In mode 1 with parity enabled, the eighth data position carries the even parity of data bits 6:0.
- R4: Modes 2 and 3 send a start bit, 9 bits LSB first and a stop bit. The ninth bit is control bit 4, except in mode 3 with parity enabled, where it is the even parity of the 8 data bits.
- R5: With receive enable set in an asynchronous mode, a received frame is delivered to address 0 and sets status bit 0 and rx_irq. With receive enable clear, frames have no effect.
- R6: In mode 2 a frame whose ninth bit is 0 is discarded. One whose ninth bit is 1 is delivered, with that bit shown in status bit 5. Mode 3 delivers every frame.
- R7: A parity mismatch on reception sets status bit 3. Mode 1 checks all 8 received bits and mode 3 checks all 9.
- R8: A 0 stop bit sets status bit 2, and the byte is still delivered.
- R9: A frame that completes while the previous byte is still unread sets status bit 4 and leaves the earlier byte in place.
- R10: A second byte may be written while a frame is being sent. Both go out in order, and each completed transmit frame sets status bit 1 and tx_irq.
- R11: Reading status clears bits 4:0. A flag raised in the same cycle as the read survives.
- R12: Mode 0 shifts 8 bits LSB first. Each bit is valid at the rising edge of sclk, and sclk is low for the first half of each bit. With receive enable clear, the block drives rxd_out and raises rxd_oe. With receive enable set, it samples rxd_in, then delivers the byte and sets status bit 0.
- R13: A bit lasts 8 x (reload + 1) clock cycles, where reload is the value written to address 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects on data and status) |
| addr | input | 2 | Register select: 0 data, 1 control, 2 baud reload, 3 status |
| wdata | input | 15 | Write data |
| rdata | output | 15 | Read data for the selected register |
| txd | output | 1 | Asynchronous transmit line |
| rxd_in | input | 1 | Receive line, also shift-mode input |
| rxd_out | output | 1 | Shift-mode data out |
| rxd_oe | output | 1 | Drive enable for rxd_out |
| sclk | output | 1 | Shift-mode clock |
| tx_irq | output | 1 | Transmit interrupt (status bit 1) |
| rx_irq | output | 1 | Receive interrupt (status bit 0) |

## Verification
A status read and a frame completion can land in the same cycle. The read clears the flags and the completion sets them. To provoke this, the bench holds the status read strobe high on every cycle while a frame arrives, and ORs together every value it reads back. The receive flag must appear in at least one of those reads, which shows that the set took priority over the clear. Random bytes in each mode are compared against frames that the bench builds from the format rules.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [1:0] M_SYNC   = 2'd0;
  localparam logic [1:0] M_ASYNC8 = 2'd1;
  localparam logic [1:0] M_ASYNC9A = 2'd2;
  localparam logic [1:0] M_ASYNC9B = 2'd3;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_BAUD = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam int F_RI = 0;
  localparam int F_TI = 1;
  localparam int F_FE = 2;
  localparam int F_PE = 3;
  localparam int F_OE = 4;
  localparam int NFLAG = 5;

  function automatic logic maj3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[1] & s[2]) | (s[0] & s[2]);
  endfunction
endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] reload,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == '0);
    cnt_d = tick ? reload : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] mode,
  input  logic       par_en,
  input  logic       rx_en,
  input  logic       b9,
  input  logic       wr,
  input  logic [7:0] wbyte,
  input  logic       rxd,
  output logic       txd,
  output logic       dout,
  output logic       doe,
  output logic       sclk,
  output logic       busy,
  output logic       tx_done,
  output logic       m0_done,
  output logic [7:0] m0_data
);
  logic [7:0]  hold_q, hold_d, mrx_q, mrx_d;
  logic        full_q, full_d, busy_q, busy_d, m0_q, m0_d, m0rx_q, m0rx_d;
  logic [10:0] sh_q, sh_d, frame;
  logic [3:0]  cnt_q, cnt_d, nb;
  logic [2:0]  sub_q, sub_d;
  logic        nine;

  always_comb begin
    nine = (mode == M_ASYNC9B && par_en) ? ^hold_q : b9;
    case (mode)
      M_SYNC:   begin frame = {3'b111, hold_q}; nb = 4'd8; end
      M_ASYNC8: begin
        frame = {2'b11, (par_en ? ^hold_q[6:0] : hold_q[7]), hold_q[6:0], 1'b0};
        nb = 4'd10;
      end
      default:  begin frame = {1'b1, nine, hold_q, 1'b0}; nb = 4'd11; end
    endcase
  end

  always_comb begin
    hold_d = hold_q; full_d = full_q; busy_d = busy_q; m0_d = m0_q; m0rx_d = m0rx_q;
    sh_d = sh_q; cnt_d = cnt_q; sub_d = sub_q; mrx_d = mrx_q;
    tx_done = 1'b0; m0_done = 1'b0;
    if (wr) begin hold_d = wbyte; full_d = 1'b1; end
    if (!busy_q) begin
      if (full_q) begin
        busy_d = 1'b1; sh_d = frame; cnt_d = nb - 4'd1; sub_d = '0;
        full_d = wr;
        m0_d   = (mode == M_SYNC);
        m0rx_d = (mode == M_SYNC) && rx_en;
      end
    end else if (tick) begin
      sub_d = sub_q + 3'd1;
      if (m0rx_q && sub_q == 3'd3) mrx_d = {rxd, mrx_q[7:1]};
      if (sub_q == 3'd7) begin
        if (cnt_q == '0) begin
          busy_d  = 1'b0;
          tx_done = !m0rx_q;
          m0_done = m0rx_q;
        end else begin
          sh_d  = {1'b1, sh_q[10:1]};
          cnt_d = cnt_q - 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0; full_q <= 1'b0; busy_q <= 1'b0; m0_q <= 1'b0; m0rx_q <= 1'b0;
      sh_q <= '1; cnt_q <= '0; sub_q <= '0; mrx_q <= '0;
    end else begin
      hold_q <= hold_d; full_q <= full_d; busy_q <= busy_d; m0_q <= m0_d; m0rx_q <= m0rx_d;
      sh_q <= sh_d; cnt_q <= cnt_d; sub_q <= sub_d; mrx_q <= mrx_d;
    end
  end

  assign txd     = (busy_q && !m0_q) ? sh_q[0] : 1'b1;
  assign dout    = sh_q[0];
  assign doe     = busy_q && m0_q && !m0rx_q;
  assign sclk    = !(busy_q && m0_q && !sub_q[2]);
  assign busy    = busy_q;
  assign m0_data = mrx_q;
endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       nine,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] data,
  output logic       b9,
  output logic       ferr
);
  typedef enum logic [1:0] {R_IDLE, R_RUN, R_WAIT} rx_st_e;
  rx_st_e      st_q, st_d;
  logic [2:0]  sub_q, sub_d, smp_q, smp_d;
  logic [3:0]  bi_q, bi_d, last;
  logic [8:0]  sh_q, sh_d;
  logic        maj;

  always_comb begin
    st_d = st_q; sub_d = sub_q; smp_d = smp_q; bi_d = bi_q; sh_d = sh_q;
    done = 1'b0; ferr = 1'b0;
    last = nine ? 4'd10 : 4'd9;
    maj  = maj3({smp_q[1:0], rxd});
    if (!en) st_d = R_IDLE;
    else if (tick) begin
      case (st_q)
        R_IDLE: if (!rxd) begin st_d = R_RUN; sub_d = 3'd1; bi_d = '0; end
        R_RUN: begin
          sub_d = sub_q + 3'd1;
          if (sub_q >= 3'd3 && sub_q <= 3'd5) smp_d = {smp_q[1:0], rxd};
          if (sub_q == 3'd5) begin
            if (bi_q == '0) begin
              if (maj) st_d = R_IDLE;
            end else if (bi_q == last) begin
              done = 1'b1; ferr = !maj; st_d = R_WAIT;
            end else sh_d = {maj, sh_q[8:1]};
          end
          if (sub_q == 3'd7) bi_d = bi_q + 4'd1;
        end
        default: if (rxd) st_d = R_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= R_IDLE; sub_q <= '0; smp_q <= '1; bi_q <= '0; sh_q <= '0;
    end else begin
      st_q <= st_d; sub_q <= sub_d; smp_q <= smp_d; bi_q <= bi_d; sh_q <= sh_d;
    end
  end

  assign data = nine ? sh_q[7:0] : sh_q[8:1];
  assign b9   = nine & sh_q[8];
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int BAUD_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BAUD_W-1:0] wdata,
  output logic [BAUD_W-1:0] rdata,
  output logic              txd,
  input  logic              rxd_in,
  output logic              rxd_out,
  output logic              rxd_oe,
  output logic              sclk,
  output logic              tx_irq,
  output logic              rx_irq
);
  localparam int CTRL_W = 5;

  logic [1:0]        rs_q, rxs_q;
  logic              rst_i, rxd_s, tick;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [BAUD_W-1:0] baud_q, baud_d;
  logic [NFLAG-1:0]  flag_q, flag_d, flag_set;
  logic [7:0]        rx_data_q, rx_data_d, ar_data, m0_data;
  logic              rx_b9_q, rx_b9_d, rx_full_q, rx_full_d;
  logic [1:0]        mode;
  logic              tx_busy, tx_done, m0_done, ar_done, ar_b9, ar_ferr;
  logic              tx_wr, rx_rd, st_rd, rx_accept, overrun, perr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rxs_q <= 2'b11;
    else        rxs_q <= {rxs_q[0], rxd_in};
  end
  assign rxd_s = rxs_q[1];

  assign mode  = ctrl_q[1:0];
  assign tx_wr = wr_en && addr == A_DATA;
  assign rx_rd = rd_en && addr == A_DATA;
  assign st_rd = rd_en && addr == A_STAT;

  sio_baud #(.W(BAUD_W)) u_baud (.clk(clk), .rst_n(rst_i), .reload(baud_q), .tick(tick));

  sio_tx u_tx (
    .clk(clk), .rst_n(rst_i), .tick(tick), .mode(mode), .par_en(ctrl_q[2]),
    .rx_en(ctrl_q[3]), .b9(ctrl_q[4]), .wr(tx_wr), .wbyte(wdata[7:0]), .rxd(rxd_s),
    .txd(txd), .dout(rxd_out), .doe(rxd_oe), .sclk(sclk), .busy(tx_busy),
    .tx_done(tx_done), .m0_done(m0_done), .m0_data(m0_data));

  sio_rx u_rx (
    .clk(clk), .rst_n(rst_i), .tick(tick), .en(ctrl_q[3] && mode != M_SYNC),
    .nine(mode[1]), .rxd(rxd_s), .done(ar_done), .data(ar_data), .b9(ar_b9), .ferr(ar_ferr));

  always_comb begin
    ctrl_d = ctrl_q; baud_d = baud_q;
    if (wr_en && addr == A_CTRL) ctrl_d = wdata[CTRL_W-1:0];
    if (wr_en && addr == A_BAUD) baud_d = wdata;
    rx_accept = (ar_done && (mode != M_ASYNC9A || ar_b9)) || m0_done;
    overrun   = rx_accept && rx_full_q && !rx_rd;
    perr      = ar_done && ctrl_q[2] &&
                ((mode == M_ASYNC8 && ^ar_data) || (mode == M_ASYNC9B && ^{ar_b9, ar_data}));
    flag_set         = '0;
    flag_set[F_RI]   = rx_accept;
    flag_set[F_TI]   = tx_done;
    flag_set[F_FE]   = rx_accept && ar_done && ar_ferr;
    flag_set[F_PE]   = rx_accept && perr;
    flag_set[F_OE]   = overrun;
    flag_d    = (st_rd ? '0 : flag_q) | flag_set;
    rx_data_d = rx_data_q; rx_b9_d = rx_b9_q; rx_full_d = rx_full_q;
    if (rx_rd) rx_full_d = 1'b0;
    if (rx_accept && !overrun) begin
      rx_data_d = m0_done ? m0_data : ar_data;
      rx_b9_d   = !m0_done && ar_b9;
      rx_full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q <= '0; baud_q <= '0; flag_q <= '0;
      rx_data_q <= '0; rx_b9_q <= 1'b0; rx_full_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d; baud_q <= baud_d; flag_q <= flag_d;
      rx_data_q <= rx_data_d; rx_b9_q <= rx_b9_d; rx_full_q <= rx_full_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DATA:  rdata[7:0]        = rx_data_q;
      A_CTRL:  rdata[CTRL_W-1:0] = ctrl_q;
      A_BAUD:  rdata             = baud_q;
      default: rdata[NFLAG:0]    = {rx_b9_q, flag_q};
    endcase
  end

  assign tx_irq = flag_q[F_TI];
  assign rx_irq = flag_q[F_RI];
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       sclk,
  input logic       tx_busy,
  input logic       rxd_oe,
  input logic [1:0] mode,
  input logic       rx_irq,
  input logic       rx_b9,
  input logic       ovr,
  input logic       rx_full,
  input logic       st_rd,
  input logic       rx_accept
);
  // R1
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> (txd && sclk));
  // R12
  sync_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_oe |-> (mode == 2'd0));
  // R9
  overrun_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rx_full));
  // R6
  addr_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_irq) && mode == 2'd2) |-> rx_b9);
  // R11
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_rd) && !$past(rx_accept)) |-> !rx_irq);
endmodule

bind sio_port sio_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .sclk(sclk), .tx_busy(tx_busy),
  .rxd_oe(rxd_oe), .mode(mode), .rx_irq(rx_irq), .rx_b9(rx_b9_q),
  .ovr(flag_q[4]), .rx_full(rx_full_q), .st_rd(st_rd), .rx_accept(rx_accept));

// File: tb/sio_port_tb.sv
module sio_port_tb;
  logic clk = 1'b0;
  logic rst_n, wr_en, rd_en, rxd_in;
  logic [1:0] addr;
  logic [14:0] wdata, rdata;
  logic txd, rxd_out, rxd_oe, sclk, tx_irq, rx_irq;
  int n_chk = 0, n_fail = 0, bitc = 16;
  bit fin, ended = 0;
  logic [14:0] acc;

  always #4 clk = ~clk;

  sio_port u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .txd(txd), .rxd_in(rxd_in), .rxd_out(rxd_out),
    .rxd_oe(rxd_oe), .sclk(sclk), .tx_irq(tx_irq), .rx_irq(rx_irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [14:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [14:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  // frame bits LSB first: start, payload, stop
  function automatic logic [10:0] fr8(input logic [7:0] d, input bit par);
    logic [7:0] p = d;
    if (par) p[7] = ^d[6:0];
    return {2'b11, p, 1'b0};
  endfunction
  function automatic logic [10:0] fr9(input logic [7:0] d, input logic n9);
    return {1'b1, n9, d, 1'b0};
  endfunction

  task automatic cap(input int n, output logic [10:0] got);
    got = '1;
    while (txd) @(negedge clk);
    repeat (bitc / 2) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      got[i] = txd;
      if (i < n - 1) repeat (bitc) @(negedge clk);
    end
  endtask

  task automatic send(input logic [10:0] b, input int n);
    for (int i = 0; i < n; i++) begin rxd_in = b[i]; repeat (bitc) @(negedge clk); end
    rxd_in = 1'b1; repeat (bitc) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [14:0] r;
    logic [10:0] g, g2;
    logic [7:0] d, d2;
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; rxd_in = 1'b1; addr = '0; wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd && sclk && !rxd_oe && !tx_irq && !rx_irq, "R1 pins", {txd, sclk, rxd_oe, tx_irq, rx_irq}, 5'b11000);
    rd(2'd3, r); chk(r == 0, "R1 status", r, 0);
    wr(2'd2, 15'd1);

    wr(2'd1, 15'h01);
    for (int k = 0; k < 4; k++) begin
      d = 8'($urandom);
      wr(2'd0, {7'd0, d}); cap(10, g);
      chk(g[9:0] == fr8(d, 0) [9:0], "R2 mode1 frame", g[9:0], fr8(d, 0));
      repeat (20) @(negedge clk);
    end
    wr(2'd1, 15'h05);
    for (int k = 0; k < 3; k++) begin
      d = 8'($urandom);
      wr(2'd0, {7'd0, d}); cap(10, g);
      chk(g[9:0] == fr8(d, 1) [9:0], "R3 parity frame", g[9:0], fr8(d, 1));
      repeat (20) @(negedge clk);
    end
    wr(2'd1, 15'h12); d = 8'($urandom);
    wr(2'd0, {7'd0, d}); cap(11, g);
    chk(g == fr9(d, 1), "R4 mode2 ninth=1", g, fr9(d, 1)); repeat (20) @(negedge clk);
    wr(2'd1, 15'h03); d = 8'($urandom);
    wr(2'd0, {7'd0, d}); cap(11, g);
    chk(g == fr9(d, 0), "R4 mode3 ninth=0", g, fr9(d, 0)); repeat (20) @(negedge clk);
    wr(2'd1, 15'h17); d = 8'($urandom);
    wr(2'd0, {7'd0, d}); cap(11, g);
    chk(g == fr9(d, ^d), "R4 mode3 parity", g, fr9(d, ^d)); repeat (20) @(negedge clk);

    wr(2'd1, 15'h01); rd(2'd3, r);
    d = 8'($urandom); d2 = ~d;
    wr(2'd0, {7'd0, d}); wr(2'd0, {7'd0, d2});
    cap(10, g); cap(10, g2);
    chk(g[9:0] == fr8(d, 0) [9:0], "R10 first", g[9:0], fr8(d, 0));
    chk(g2[9:0] == fr8(d2, 0) [9:0], "R10 second", g2[9:0], fr8(d2, 0));
    repeat (20) @(negedge clk);
    chk(tx_irq, "R10 tx_irq", tx_irq, 1);
    rd(2'd3, r); chk(r[1] == 1'b1, "R10 TI", r, 2);
    rd(2'd3, r); chk(r[4:0] == 0, "R11 cleared", r, 0);

    wr(2'd2, 15'd3); bitc = 32;
    wr(2'd0, 15'h55);
    begin
      int len = 0;
      while (txd) @(negedge clk);
      while (!txd) begin len++; @(negedge clk); end
      chk(len >= 29 && len <= 32, "R13 bit length", len, 32);
    end
    repeat (11 * 32) @(negedge clk);
    wr(2'd2, 15'd1); bitc = 16;

    wr(2'd1, 15'h09); rd(2'd3, r);
    for (int k = 0; k < 3; k++) begin
      d = 8'($urandom);
      send(fr8(d, 0), 10);
      chk(rx_irq, "R5 rx_irq", rx_irq, 1);
      rd(2'd0, r); chk(r[7:0] == d, "R5 data", r, d);
      rd(2'd3, r); chk(r[0] && r[4:2] == 0, "R5 status", r, 1);
    end
    wr(2'd1, 15'h01); send(fr8(8'hA5, 0), 10);
    rd(2'd3, r); chk(r[0] == 0 && !rx_irq, "R5 disabled", r, 0);

    wr(2'd1, 15'h0A); d = 8'($urandom);
    send(fr9(d, 0), 11);
    chk(!rx_irq, "R6 mode2 ninth=0 dropped", rx_irq, 0);
    send(fr9(d, 1), 11);
    rd(2'd0, r); chk(r[7:0] == d, "R6 mode2 data", r, d);
    rd(2'd3, r); chk(r[0] && r[5], "R6 mode2 status", r, 6'h21);
    wr(2'd1, 15'h0B); send(fr9(~d, 0), 11);
    rd(2'd0, r); chk(r[7:0] == ~d, "R6 mode3 data", r, ~d);
    rd(2'd3, r); chk(r[0] && !r[5], "R6 mode3 status", r, 1);

    wr(2'd1, 15'h0D); d = 8'($urandom);
    send(fr8(d, 1) ^ 11'h100, 10);
    rd(2'd0, r); rd(2'd3, r); chk(r[3], "R7 mode1 bad parity", r, 8);
    send(fr8(d, 1), 10);
    rd(2'd0, r); rd(2'd3, r); chk(r[0] && !r[3], "R7 mode1 good parity", r, 1);
    wr(2'd1, 15'h0F);
    send(fr9(d, ~^d), 11);
    rd(2'd0, r); rd(2'd3, r); chk(r[3], "R7 mode3 bad parity", r, 8);

    wr(2'd1, 15'h09); d = 8'($urandom);
    send(fr8(d, 0) & 11'h1FF, 10);
    rd(2'd0, r); chk(r[7:0] == d, "R8 data kept", r, d);
    rd(2'd3, r); chk(r[2], "R8 FE", r, 4);

    d = 8'($urandom);
    send(fr8(d, 0), 10); send(fr8(~d, 0), 10);
    rd(2'd3, r); chk(r[4], "R9 OE", r, 16'h11);
    rd(2'd0, r); chk(r[7:0] == d, "R9 first kept", r, d);

    fin = 0; acc = '0; d = 8'($urandom);
    fork
      begin send(fr8(d, 0), 10); fin = 1; end
      begin
        while (!fin) begin @(negedge clk); addr = 2'd3; rd_en = 1'b1; #1 acc |= rdata; end
        rd_en = 1'b0;
      end
    join
    chk(acc[0] == 1'b1, "R11 set beats clear", acc, 1);
    rd(2'd0, r); chk(r[7:0] == d, "R11 data", r, d);

    wr(2'd1, 15'h00); rd(2'd3, r);
    d = 8'($urandom);
    begin
      bit oe_ok = 1;
      wr(2'd0, {7'd0, d});
      for (int i = 0; i < 8; i++) begin
        while (sclk) @(negedge clk);
        while (!sclk) @(negedge clk);
        g[i] = rxd_out; oe_ok &= rxd_oe;
      end
      chk(g[7:0] == d, "R12 sync out", g[7:0], d);
      chk(oe_ok, "R12 oe driven", oe_ok, 1);
    end
    repeat (30) @(negedge clk);
    wr(2'd1, 15'h08); rd(2'd3, r);
    d = 8'($urandom);
    begin
      bit oe_bad = 0;
      rxd_in = d[0];
      wr(2'd0, 15'h0);
      for (int i = 0; i < 8; i++) begin
        while (sclk) @(negedge clk);
        while (!sclk) begin oe_bad |= rxd_oe; @(negedge clk); end
        if (i < 7) rxd_in = d[i + 1];
      end
      rxd_in = 1'b1;
      repeat (30) @(negedge clk);
      chk(!oe_bad, "R12 line released", oe_bad, 0);
    end
    rd(2'd0, r); chk(r[7:0] == d, "R12 sync in", r, d);
    rd(2'd3, r); chk(r[0] && !r[1], "R12 sync RI", r, 1);

    ended = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule